// File: doc/BRIEF.md
# Serial Converter Command Front End

This block is the digital receive side of a serially programmed converter. A host lowers an active-low frame strobe, clocks in sixteen bits on a serial clock and data pair, and raises the strobe again. Every input is synchronized into one fast system clock, and serial clock transitions are found by edge detection. The block counts the active serial edges. On the sixteenth it takes the frame, reads the control code in the top four bits, and acts on the twelve-bit payload below it.

A command can load the twelve-bit converter code. Another can swap the capture edge between falling (the reset choice) and rising. A third can arm a one-shot readback, so that the next frame sends the stored code out on the serial output. The serial output always moves on the edge opposite to capture. With no readback armed, it sends out the previous contents of the shift register, so several devices can be chained.

Top module: `sdac_frontend`

## Requirements
- R1: After reset the converter code is 0, the serial output is 0, no load pulse is issued and capture uses the falling serial clock edge.
- R2: A complete frame whose top four bits are 0001 copies its low twelve bits to the converter code and raises the load output for exactly one system clock cycle. The code changes at no other time.
- R3: With falling-edge capture selected, the serial data bit is taken at falling serial clock edges. Frames are most significant bit first.
- R4: A complete frame with control code 1001 makes later frames capture on rising edges. Code 1010 restores falling-edge capture.
- R5: If the strobe rises before sixteen active edges, the frame changes neither the converter code nor the edge selection nor the readback state.
- R6: Active edges after the sixteenth in one frame are ignored, and the frame acts on its first sixteen bits only.
- R7: While the strobe is low, the serial output presents the shift register's most significant bit and advances only on the non-capture edge. With no readback armed, a frame sends out the bits the register held before it, most significant first.
- R8: A complete frame with code 0010 arms a readback. The next frame sends out four zero bits followed by the twelve-bit converter code. The frame after that sends out shift-register contents again.
- R9: Control codes other than 0001, 0010, 1001 and 1010 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least eight times the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock, sampled asynchronously |
| sync_n_i | input | 1 | Active-low frame strobe |
| sdin_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out, moves on the non-capture edge |
| dac_code_o | output | 12 | Stored converter code |
| dac_load_o | output | 1 | One-cycle pulse when the code is loaded |

## Verification
The bench drives each data bit before the capture edge and inverts it just after, so capturing on the wrong edge loads a corrupted code. This makes a failed rising-edge switch or a missed restore visible at once. Frames cut short and frames run long are sent with load commands inside them. A counter that is not reset at the strobe would carry a partial frame forward, and a counter that does not saturate would act on a late bit; either one shows up as a wrong code. The serial output is compared word by word against a model shift register, and that model includes the one-shot readback substitution. A readback that stays armed, or one that is never taken, gives the wrong following word.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

    typedef enum logic [3:0] {
        CMD_NOP       = 4'b0000,
        CMD_LOAD      = 4'b0001,
        CMD_READBACK  = 4'b0010,
        CMD_EDGE_RISE = 4'b1001,
        CMD_EDGE_FALL = 4'b1010
    } sdac_cmd_e;

endpackage

// File: rtl/sdac_insync.sv
module sdac_insync #(
    parameter int W       = 3,
    parameter int STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            stg_d[s] = stg_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                stg_q[s] <= RST_VAL;
            end
        end else begin
            for (int s = 0; s < STAGES; s++) begin
                stg_q[s] <= stg_d[s];
            end
        end
    end

    assign sync_o = stg_q[STAGES-1];

endmodule

// File: rtl/sdac_shift.sv
module sdac_shift #(
    parameter int FRAME_W = 16,
    localparam int CNT_W  = $clog2(FRAME_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               act_i,
    input  logic               opp_i,
    input  logic               sdin_i,
    input  logic               reload_i,
    input  logic [FRAME_W-1:0] reload_word_i,
    output logic               sdo_o,
    output logic               done_o,
    output logic [FRAME_W-1:0] frame_o
);

    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_W - 1);

    typedef struct packed {
        logic [FRAME_W-1:0] sh;
        logic [CNT_W-1:0]   cnt;
        logic               sdo;
        logic               done;
        logic [FRAME_W-1:0] frame;
    } shift_st_t;

    shift_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (start_i) begin
            st_d.cnt = '0;
            if (reload_i) begin
                st_d.sh  = reload_word_i;
                st_d.sdo = reload_word_i[FRAME_W-1];
            end else begin
                st_d.sdo = st_q.sh[FRAME_W-1];
            end
        end else if (act_i && (st_q.cnt < CNT_FULL)) begin
            st_d.sh  = {st_q.sh[FRAME_W-2:0], sdin_i};
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == CNT_LAST) begin
                st_d.done  = 1'b1;
                st_d.frame = {st_q.sh[FRAME_W-2:0], sdin_i};
            end
        end else if (opp_i && (st_q.cnt < CNT_FULL)) begin
            st_d.sdo = st_q.sh[FRAME_W-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.cnt <= CNT_FULL;
        end else begin
            st_q <= st_d;
        end
    end

    assign sdo_o   = st_q.sdo;
    assign done_o  = st_q.done;
    assign frame_o = st_q.frame;

    a_r6_count_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_FULL);
    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> !st_q.done);
    a_r6_done_at_full: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> (st_q.cnt == CNT_FULL));
    a_r7_sdo_moves_on_opp: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.sdo) |-> $past(opp_i || start_i));

endmodule

// File: rtl/sdac_ctrl.sv
module sdac_ctrl
    import sdac_pkg::*;
#(
    parameter int FRAME_W = 16,
    parameter int CODE_W  = 4,
    localparam int DATA_W = FRAME_W - CODE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               done_i,
    input  logic [FRAME_W-1:0] frame_i,
    output logic               rise_sel_o,
    output logic               rb_arm_o,
    output logic [DATA_W-1:0]  data_o,
    output logic               load_o
);

    typedef struct packed {
        logic              rise_sel;
        logic              rb_arm;
        logic [DATA_W-1:0] data;
        logic              load;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;
    logic [3:0] code_w;

    always_comb begin
        code_w    = 4'(frame_i[FRAME_W-1 -: CODE_W]);
        st_d      = st_q;
        st_d.load = 1'b0;
        if (start_i) begin
            st_d.rb_arm = 1'b0;
        end
        if (done_i) begin
            case (code_w)
                CMD_LOAD: begin
                    st_d.data = frame_i[DATA_W-1:0];
                    st_d.load = 1'b1;
                end
                CMD_READBACK:  st_d.rb_arm   = 1'b1;
                CMD_EDGE_RISE: st_d.rise_sel = 1'b1;
                CMD_EDGE_FALL: st_d.rise_sel = 1'b0;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rise_sel_o = st_q.rise_sel;
    assign rb_arm_o   = st_q.rb_arm;
    assign data_o     = st_q.data;
    assign load_o     = st_q.load;

    a_r2_code_moves_with_load: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.data) |-> st_q.load);
    a_r2_load_follows_frame: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.load |-> $past(done_i));
    a_r8_arm_consumed: assert property (@(posedge clk) disable iff (!rst_n)
        $past(start_i) |-> !st_q.rb_arm);
    a_r4_edge_only_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.rise_sel) |-> $past(done_i));

endmodule

// File: rtl/sdac_frontend.sv
module sdac_frontend #(
    parameter int FRAME_W     = 16,
    parameter int CODE_W      = 4,
    parameter int SYNC_STAGES = 2,
    localparam int DATA_W     = FRAME_W - CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              sync_n_i,
    input  logic              sdin_i,
    output logic              sdo_o,
    output logic [DATA_W-1:0] dac_code_o,
    output logic              dac_load_o
);

    typedef struct packed {
        logic sclk_prev;
        logic sync_prev;
    } edge_st_t;

    edge_st_t st_d, st_q;

    logic [2:0]         pins_s;
    logic               sclk_s, sync_s, sdin_s;
    logic               sclk_rise, sclk_fall, sync_fall, framing;
    logic               act_edge, opp_edge;
    logic               rise_sel, rb_arm, done;
    logic [FRAME_W-1:0] frame_w;
    logic [DATA_W-1:0]  data_w;
    logic [FRAME_W-1:0] reload_word;

    sdac_insync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b010)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({sclk_i, sync_n_i, sdin_i}),
        .sync_o  (pins_s)
    );

    assign sclk_s = pins_s[2];
    assign sync_s = pins_s[1];
    assign sdin_s = pins_s[0];

    always_comb begin
        st_d.sclk_prev = sclk_s;
        st_d.sync_prev = sync_s;
        sclk_rise = sclk_s & ~st_q.sclk_prev;
        sclk_fall = ~sclk_s & st_q.sclk_prev;
        sync_fall = ~sync_s & st_q.sync_prev;
        framing   = ~sync_s;
        act_edge  = framing & ~sync_fall & (rise_sel ? sclk_rise : sclk_fall);
        opp_edge  = framing & ~sync_fall & (rise_sel ? sclk_fall : sclk_rise);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sclk_prev <= 1'b0;
            st_q.sync_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign reload_word = {{CODE_W{1'b0}}, data_w};

    sdac_shift #(
        .FRAME_W (FRAME_W)
    ) u_shift (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (sync_fall),
        .act_i         (act_edge),
        .opp_i         (opp_edge),
        .sdin_i        (sdin_s),
        .reload_i      (rb_arm),
        .reload_word_i (reload_word),
        .sdo_o         (sdo_o),
        .done_o        (done),
        .frame_o       (frame_w)
    );

    sdac_ctrl #(
        .FRAME_W (FRAME_W),
        .CODE_W  (CODE_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (sync_fall),
        .done_i     (done),
        .frame_i    (frame_w),
        .rise_sel_o (rise_sel),
        .rb_arm_o   (rb_arm),
        .data_o     (data_w),
        .load_o     (dac_load_o)
    );

    assign dac_code_o = data_w;

    a_r4_edges_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({act_edge, opp_edge}));
    a_r5_no_capture_idle: assert property (@(posedge clk) disable iff (!rst_n)
        sync_s |-> !(act_edge || opp_edge));

endmodule

// File: tb/tb_sdac_frontend.sv
`timescale 1ns/1ps
module tb_sdac_frontend;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b1;
    logic        sync_n = 1'b1;
    logic        sdin = 1'b0;
    logic        sdo;
    logic [11:0] code;
    logic        load;

    int n_chk = 0;
    int n_bad = 0;
    int loads_seen = 0;
    int loads_exp = 0;
    bit done_flag = 1'b0;

    logic [15:0] m_sh = '0;
    logic [11:0] m_code = '0;
    bit          m_rise = 1'b0;
    bit          m_rb = 1'b0;
    logic [15:0] got_sdo;
    logic [15:0] exp_sdo;

    always #4 clk = ~clk;

    sdac_frontend dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_i     (sclk),
        .sync_n_i   (sync_n),
        .sdin_i     (sdin),
        .sdo_o      (sdo),
        .dac_code_o (code),
        .dac_load_o (load)
    );

    always @(posedge clk) if (rst_n && load) loads_seen++;

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Sends one frame of nedges active edges; records SDO seen before each active edge
    task automatic send(input logic [15:0] w, input int nedges);
        int used;
        exp_sdo = m_rb ? {4'b0000, m_code} : m_sh;
        m_sh = exp_sdo;
        m_rb = 1'b0;
        got_sdo = '0;
        sclk = m_rise ? 1'b0 : 1'b1;
        cyc(10);
        sync_n = 1'b0;
        cyc(10);
        for (int i = 0; i < nedges; i++) begin
            sdin = (i < 16) ? w[15-i] : ~w[0];
            cyc(6);
            if (i < 16) got_sdo[15-i] = sdo;
            sclk = ~sclk;
            cyc(3);
            sdin = ~sdin;
            cyc(3);
            sclk = ~sclk;
        end
        cyc(6);
        sync_n = 1'b1;
        cyc(10);
        used = (nedges < 16) ? nedges : 16;
        if (used == 16) begin
            m_sh = w;
            case (w[15:12])
                4'b0001: begin m_code = w[11:0]; loads_exp++; end
                4'b0010: m_rb = 1'b1;
                4'b1001: m_rise = 1'b1;
                4'b1010: m_rise = 1'b0;
                default: ;
            endcase
        end else if (used > 0) begin
            m_sh = (m_sh << used) | 16'(w >> (16 - used));
        end
    endtask

    task automatic sdo_chk(input string tag, input int nbits);
        logic [15:0] mask;
        mask = (nbits >= 16) ? 16'hFFFF : ~(16'hFFFF >> nbits);
        chk((got_sdo & mask) == (exp_sdo & mask), tag, 32'(got_sdo & mask), 32'(exp_sdo & mask));
    endtask

    initial begin
        #1_500_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [11:0] v;
        cyc(5);
        rst_n = 1'b1;
        cyc(5);
        // R1 reset state
        chk(code == 12'h000, "R1 code", 32'(code), 0);
        chk(sdo == 1'b0, "R1 sdo", 32'(sdo), 0);
        chk(loads_seen == 0, "R1 no load", loads_seen, 0);

        // R2 R3 R7 load sweep in falling mode
        for (int k = 0; k < 18; k++) begin
            v = (k == 16) ? 12'hFFF : (k == 17) ? 12'h000 : 12'(k * 291 + 5);
            send({4'b0001, v}, 16);
            chk(code == m_code, "R2 R3 load falling", 32'(code), 32'(m_code));
            sdo_chk("R7 daisy word", 16);
        end
        chk(loads_seen == loads_exp, "R2 one pulse per load", loads_seen, loads_exp);

        // R5 partial frames
        send({4'b0001, 12'h5A5}, 10);
        chk(code == m_code, "R5 partial ignored", 32'(code), 32'(m_code));
        sdo_chk("R7 partial word", 10);
        send({4'b1001, 12'h000}, 15);
        send({4'b0001, 12'h3C3}, 16);
        chk(code == m_code, "R5 edge kept after partial", 32'(code), 32'(m_code));

        // R6 overlong frame
        send({4'b0001, 12'h9E1}, 20);
        chk(code == 12'h9E1, "R6 overlong frame", 32'(code), 32'h9E1);

        // R9 unused codes
        for (int c = 0; c < 16; c++) begin
            if (c == 1 || c == 2 || c == 9 || c == 10) continue;
            send({4'(c), 12'hABC}, 16);
            chk(code == m_code, "R9 unused code", 32'(code), 32'(m_code));
        end
        send({4'b0001, 12'h246}, 16);
        chk(code == 12'h246, "R9 edge unchanged", 32'(code), 32'h246);

        // R8 readback in falling mode
        send({4'b0010, 12'h000}, 16);
        send({4'b0000, 12'h777}, 16);
        sdo_chk("R8 readback word", 16);
        chk(exp_sdo == {4'b0000, 12'h246}, "R8 model word", 32'(exp_sdo), 32'h246);
        send({4'b0000, 12'h111}, 16);
        sdo_chk("R8 one shot", 16);

        // R4 rising edge selection
        send({4'b1001, 12'h000}, 16);
        for (int k = 0; k < 6; k++) begin
            v = 12'(k * 683 + 77);
            send({4'b0001, v}, 16);
            chk(code == v, "R4 load rising", 32'(code), 32'(v));
            sdo_chk("R7 daisy rising", 16);
        end
        send({4'b0010, 12'h000}, 16);
        send({4'b0000, 12'h000}, 16);
        sdo_chk("R8 readback rising", 16);
        send({4'b1010, 12'h000}, 16);
        send({4'b0001, 12'hC0D}, 16);
        chk(code == 12'hC0D, "R4 restore falling", 32'(code), 32'hC0D);
        chk(loads_seen == loads_exp, "R2 pulse total", loads_seen, loads_exp);

        done_flag = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule